// File: doc/BRIEF.md
# 64-bit Down-Counting Timer with Register Interface

This block is a single-channel timer that sits on a simple 32-bit register bus. The bus has a byte address, write data, a write strobe and combinational read data. Software first writes a 64-bit reload value as two 32-bit halves. It then writes a control word that starts the timer, picks periodic or single-shot counting, and allows the interrupt line to fire.

Each cycle in which the `tick` strobe is high counts as one timer-clock tick, and the running count goes down by one on each tick. When a tick arrives while the count is already zero, the timer expires and a sticky status flag is set. In periodic mode the counter then reloads. In single-shot mode it waits at zero until the timer is started again. Software clears the flag by writing a one to it. A build parameter places the control register at one of two offsets, so that both register-map variants come from the same source.

Top module: `down_timer64`

## Requirements
- R1: After reset every register reads zero, the timer is stopped and `irq` is low.
- R2: The reload value is written as a low half at offset 0x00 and a high half at offset 0x04, and both halves read back at those offsets.
- R3: A control write that sets bit 0 (enable) while the timer is stopped copies the 64-bit reload value into the count. The count reads back with its low half at offset 0x08 and its high half at offset 0x0C.
- R4: While enabled, the count drops by one on each cycle with `tick` high. The count does not change on cycles without a tick, or while the timer is disabled.
- R5: A tick that arrives at count zero while enabled sets the status flag, which is bit 0 of offset 0x18. A reload value of N therefore gives an expiry every N+1 ticks, and N = 0 expires on every tick.
- R6: In periodic mode (control bit 1 = 0), the count is reloaded from the reload value at each expiry.
- R7: In single-shot mode (control bit 1 = 1), the count stays at zero after the first expiry and no further expiry occurs. Stopping and re-enabling the timer starts a new count from the reload value.
- R8: Writing 1 to bit 0 of offset 0x18 clears the status flag, and writing 0 there has no effect. If an expiry and a clear happen in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the status flag is set and control bit 2 (unmask) is 1. The flag stays set while the timer is disabled.
- R10: The control register lives at offset `CTRL_OFS` (0x10 or 0x1C) and reads back bits [2:0]. Writing 0 to it stops the timer. Unmapped offsets read zero, and writes to them change nothing.
- R11: A control write that keeps enable at 1 while the timer is already running does not reload the count. A new reload value takes effect only at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick strobe; one count step per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe; a write occurs on each clock edge where it is high |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request: status flag gated by the unmask bit |

## Verification
The assertions assume that `bus_addr`, `bus_we`, `bus_wdata` and `tick` are stable around each rising clock edge. They also assume one register access per cycle, and that `CTRL_OFS` does not collide with any other register offset. The bench meets these assumptions by changing inputs only on the falling edge and by issuing each write as a single-cycle strobe. It also keeps `tick` low during register writes, except in the one deliberate case where a clear and an expiry are made to coincide. Both offset variants are built side by side and share the same bus.

// File: rtl/down_timer64.sv
module down_timer64 #(
  parameter int ADDR_W = 5,
  parameter int unsigned CTRL_OFS = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int HALF = 32;
  localparam int CNT_W = 2 * HALF;
  localparam logic [ADDR_W-1:0] A_LD_LO = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LD_HI = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CN_LO = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CN_HI = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CTRL  = CTRL_OFS[ADDR_W-1:0];

  logic [HALF-1:0]  ld_lo_q, ld_hi_q;
  logic [CNT_W-1:0] count_q;
  logic [2:0]       ctrl_q;
  logic             status_q, done_q;

  wire wr_lo   = bus_we && (bus_addr == A_LD_LO);
  wire wr_hi   = bus_we && (bus_addr == A_LD_HI);
  wire wr_ctrl = bus_we && (bus_addr == A_CTRL);
  wire wr_stat = bus_we && (bus_addr == A_STAT);

  wire              en      = ctrl_q[0];
  wire              oneshot = ctrl_q[1];
  wire [CNT_W-1:0]  load_val = {ld_hi_q, ld_lo_q};
  wire              start   = wr_ctrl && bus_wdata[0] && !en;
  wire              expire  = en && tick && (count_q == '0) && !done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_lo_q <= '0;
      ld_hi_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_lo)   ld_lo_q <= bus_wdata;
      if (wr_hi)   ld_hi_q <= bus_wdata;
      if (wr_ctrl) ctrl_q  <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (start) begin
      count_q <= load_val;
      done_q  <= 1'b0;
    end else if (en && tick) begin
      if (count_q != '0)
        count_q <= count_q - 1'b1;
      else if (expire && !oneshot)
        count_q <= load_val;
      if (expire && oneshot)
        done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      status_q <= 1'b0;
    else if (expire)
      status_q <= 1'b1;
    else if (wr_stat && bus_wdata[0])
      status_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_LD_LO)      bus_rdata = ld_lo_q;
    else if (bus_addr == A_LD_HI) bus_rdata = ld_hi_q;
    else if (bus_addr == A_CN_LO) bus_rdata = count_q[HALF-1:0];
    else if (bus_addr == A_CN_HI) bus_rdata = count_q[CNT_W-1:HALF];
    else if (bus_addr == A_STAT)  bus_rdata = {31'd0, status_q};
    else if (bus_addr == A_CTRL)  bus_rdata = {29'd0, ctrl_q};
  end

  assign irq = status_q & ctrl_q[2];
endmodule

// File: rtl/down_timer64_chk.sv
module down_timer64_chk #(
  parameter int ADDR_W = 5,
  parameter int unsigned CTRL_OFS = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              wd0,
  input logic              wd2,
  input logic              irq,
  input logic              en,
  input logic              oneshot,
  input logic              done,
  input logic              status,
  input logic [63:0]       count,
  input logic [63:0]       load
);
  wire ctrl_wr = we && (addr == CTRL_OFS[ADDR_W-1:0]);
  wire stat_wr = we && (addr == ADDR_W'('h18));
  wire starting = ctrl_wr && wd0 && !en;

  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    starting |=> count == $past(load));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && count != 64'd0) |=> count == $past(count) - 64'd1);

  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !starting) |=> $stable(count));

  a_r5_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && count == 64'd0 && !done) |=> status);

  a_r7_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oneshot && done && !starting) |=> count == 64'd0);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wd0 && !(en && tick && count == 64'd0 && !done)) |=> !status);

  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wd2) |=> !irq);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !(stat_wr && wd0)) |=> status);
endmodule

bind down_timer64 down_timer64_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .we(bus_we), .addr(bus_addr),
  .wd0(bus_wdata[0]), .wd2(bus_wdata[2]), .irq(irq),
  .en(ctrl_q[0]), .oneshot(ctrl_q[1]), .done(done_q), .status(status_q),
  .count(count_q), .load({ld_hi_q, ld_lo_q})
);

// File: tb/down_timer64_tb_top.sv
module down_timer64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] rdata, rdata_alt;
  logic        irq, irq_alt;
  int          n_tests = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  down_timer64 #(.ADDR_W(5), .CTRL_OFS('h10)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(rdata), .irq(irq));

  down_timer64 #(.ADDR_W(5), .CTRL_OFS('h1C)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(rdata_alt), .irq(irq_alt));

  localparam int NV = 9;
  typedef struct packed { logic [63:0] load; logic [31:0] ticks; logic oneshot; } vec_t;
  localparam vec_t VECS [NV] = '{
    '{64'd5, 32'd3, 1'b0},
    '{64'd5, 32'd6, 1'b0},
    '{64'd5, 32'd14, 1'b0},
    '{64'd0, 32'd3, 1'b0},
    '{64'd3, 32'd4, 1'b1},
    '{64'd3, 32'd10, 1'b1},
    '{64'h0000_0001_0000_0002, 32'd5, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 32'd2, 1'b1},
    '{64'h0000_0000_FFFF_FFFF, 32'd1, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rd_count(output logic [63:0] c);
    logic [31:0] lo, hi;
    rd(5'h08, lo);
    rd(5'h0C, hi);
    c = {hi, lo};
  endtask

  task automatic setup(input logic [63:0] ld, input logic [31:0] ctrl);
    wr(5'h10, 32'd0);
    wr(5'h18, 32'd1);
    wr(5'h00, ld[31:0]);
    wr(5'h04, ld[63:32]);
    wr(5'h10, ctrl);
  endtask

  function automatic logic [63:0] exp_count(input logic [63:0] ld, input logic [63:0] k, input logic os);
    if (k <= ld) return ld - k;
    if (os) return 64'd0;
    return ld - (k % (ld + 64'd1));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], r);
      chk($sformatf("R1 reset read 0x%0h", a), {32'd0, r}, 64'd0);
    end
    chk("R1 reset irq", {63'd0, irq}, 64'd0);

    wr(5'h00, 32'hA5A5_0001);
    wr(5'h04, 32'h0000_BEEF);
    rd(5'h00, r); chk("R2 load low readback", {32'd0, r}, 64'hA5A5_0001);
    rd(5'h04, r); chk("R2 load high readback", {32'd0, r}, 64'h0000_BEEF);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].load, {29'd0, 1'b1, VECS[i].oneshot, 1'b1});
      rd_count(c);
      chk($sformatf("R3 vec%0d start load", i), c, VECS[i].load);
      ticks(int'(VECS[i].ticks));
      rd_count(c);
      e = exp_count(VECS[i].load, {32'd0, VECS[i].ticks}, VECS[i].oneshot);
      chk($sformatf("R4 R6 R7 vec%0d count", i), c, e);
      rd(5'h18, r);
      e = ({32'd0, VECS[i].ticks} > VECS[i].load) ? 64'd1 : 64'd0;
      chk($sformatf("R5 vec%0d status", i), {32'd0, r}, e);
      chk($sformatf("R9 vec%0d irq", i), {63'd0, irq}, e);
    end

    wr(5'h10, 32'd0);
    wr(5'h10, 32'd3);
    rd_count(c); chk("R7 re-enable reload", c, 64'hFFFF_FFFF);
    chk("R9 masked irq", {63'd0, irq}, 64'd0);

    setup(64'd100, 32'd5);
    ticks(3);
    wr(5'h00, 32'd7);
    wr(5'h10, 32'd5);
    rd_count(c); chk("R11 rewrite ctrl no reload", c, 64'd97);
    repeat (5) @(negedge clk);
    rd_count(c); chk("R4 hold without tick", c, 64'd97);
    wr(5'h10, 32'd0);
    ticks(4);
    rd_count(c); chk("R4 hold while disabled", c, 64'd97);
    wr(5'h10, 32'd1);
    rd_count(c); chk("R11 new load at next start", c, 64'd7);

    setup(64'd0, 32'd1);
    ticks(1);
    rd(5'h18, r); chk("R5 load0 expires", {32'd0, r}, 64'd1);
    chk("R9 masked while set", {63'd0, irq}, 64'd0);
    wr(5'h10, 32'd4);
    chk("R9 irq when unmasked and disabled", {63'd0, irq}, 64'd1);
    wr(5'h18, 32'd0);
    rd(5'h18, r); chk("R8 write 0 no effect", {32'd0, r}, 64'd1);
    wr(5'h18, 32'd1);
    rd(5'h18, r); chk("R8 write 1 clears", {32'd0, r}, 64'd0);
    chk("R9 irq drops", {63'd0, irq}, 64'd0);

    setup(64'd0, 32'd5);
    @(negedge clk);
    tick = 1'b1; bus_addr = 5'h18; bus_wdata = 32'd1; bus_we = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    rd(5'h18, r); chk("R8 set wins over clear", {32'd0, r}, 64'd1);

    wr(5'h10, 32'd0);
    wr(5'h1C, 32'd5);
    #1;
    chk("R10 alt ctrl readback", {32'd0, rdata_alt}, 64'd5);
    chk("R10 main ignores 0x1C", {32'd0, rdata}, 64'd0);
    rd(5'h10, r); chk("R10 main ctrl stopped", {32'd0, r}, 64'd0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, r); chk("R10 unmapped reads 0", {32'd0, r}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule